// File: doc/BRIEF.md
# Serial Transmit Word Buffer

This block is the transmit half of a synchronous serial port. Software or a DMA engine writes a data word into a holding register. When the output shifter is free, the word moves into it. On the next frame sync the word goes out on a single data line, most significant bit first, one bit per serial clock enable. The holding register and the shifter together act as a two-entry queue. A one-cycle refill interrupt tells the writer that the holding register can take another word.

A sticky underflow flag records any frame sync that finds no word ready to send. The only way to clear the flag, and to empty both storage stages, is to drop the enable. The word length is programmable, and shorter words sit in the low bits of the written data. The serial clock arrives as a one-cycle enable pulse in the system clock domain. Frame syncs are only honoured in pulse cycles.

Top module: `tx_serial_buf`

## Requirements
- R1: While reset is asserted, and after it is released with `en` low, `sdo`, `tx_irq` and `uflow` are all 0.
- R2: After `en` goes high, writes and frame syncs sampled on the first two rising clock edges with `en` high are ignored. From the third such edge on, the port accepts them.
- R3: A frame sync (`fsync` high in a cycle with `sclk_tick` high) that finds a word loaded starts it. `sdo` shows bit L-1 after that edge, then moves down one bit on each later tick. After bit 0 has been held for one tick period, `sdo` returns to 0. It is 0 whenever no word is being shifted.
- R4: L = `wlen_m1`+1. Written bits at positions L and above are discarded and never reach `sdo`.
- R5: A write is accepted only when the holding register is empty. A write made while it holds a word is dropped, so at most two words are stored.
- R6: When the holding register has a word and the shifter is empty, the word moves to the shifter on the next edge. `tx_irq` is high for exactly the one cycle after that edge.
- R7: `tx_irq` stays low for a transfer made while `dma_en` or `irq_mask` is high.
- R8: A frame sync that finds neither a loaded shifter nor a word in the holding register sets `uflow`. It stays set while `en` stays high.
- R9: Clearing `en` empties both stages, clears `uflow` and forces `sdo` to 0 on the next edge.
- R10: A frame sync that arrives while a word is still being shifted has no effect.
- R11: A `wlen_m1` value below 2 is treated as 2, giving a 3-bit word.
- R12: A frame sync that arrives in the same cycle as a transfer from the holding register into the empty shifter starts that word at once. The transfer raises `tx_irq` and does not set `uflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low clears all state |
| wlen_m1 | input | 5 | Word length minus one |
| dma_en | input | 1 | DMA mode, suppresses the refill interrupt |
| irq_mask | input | 1 | Masks the refill interrupt |
| wr | input | 1 | Write strobe for the holding register |
| wdata | input | 32 | Word to transmit, right-justified |
| sclk_tick | input | 1 | Serial clock enable, one pulse per bit |
| fsync | input | 1 | Frame sync, valid with `sclk_tick` |
| sdo | output | 1 | Serial data out |
| tx_irq | output | 1 | One-cycle refill interrupt |
| uflow | output | 1 | Sticky underflow flag |

## Verification
Two functions can land on the same edge: the handover of a held word into an empty shifter, and a frame sync that tries to start transmission. The bench writes a word with the serial clock enable running every cycle, then raises frame sync on the very next cycle, when the handover occurs. The expected result is a refill interrupt, the most significant bit on `sdo` one edge later, and `uflow` still low. A second case applies a write and a frame sync together on an empty buffer. There the expected result is that `uflow` is set while the word is still accepted and sent on the following frame.

// File: rtl/tx_serial_buf_pkg.sv
package tx_serial_buf_pkg;
    typedef enum logic [1:0] {
        SH_EMPTY  = 2'd0,
        SH_LOADED = 2'd1,
        SH_SHIFT  = 2'd2
    } sh_state_e;
endpackage

// File: rtl/txb_enable_gate.sv
module txb_enable_gate #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ready
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        g_d.pipe[0] = 1'b1;
        for (int i = 1; i < STAGES; i++) begin
            g_d.pipe[i] = g_q.pipe[i-1];
        end
        if (!en) begin
            g_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign ready = g_q.pipe[STAGES-1] & en;
endmodule

// File: rtl/txb_hold.sv
module txb_hold #(
    parameter int DW = 32,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rdy,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [LW-1:0] len_m1,
    input  logic          take,
    output logic          valid,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } hold_t;

    hold_t h_d, h_q;
    logic [DW-1:0] keep;

    for (genvar i = 0; i < DW; i++) begin : g_keep
        assign keep[i] = (LW'(i) <= len_m1);
    end

    always_comb begin
        h_d = h_q;
        if (take) begin
            h_d.valid = 1'b0;
        end
        if (rdy && wr && !h_q.valid) begin
            h_d.valid = 1'b1;
            h_d.data  = wdata & keep;
        end
        if (clr) begin
            h_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign valid = h_q.valid;
    assign data  = h_q.data;
endmodule

// File: rtl/txb_shifter.sv
module txb_shifter
    import tx_serial_buf_pkg::*;
#(
    parameter int DW = 32,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rdy,
    input  logic          tick,
    input  logic          fsync,
    input  logic          hvalid,
    input  logic [DW-1:0] hdata,
    input  logic [LW-1:0] len_m1,
    input  logic          dma_en,
    input  logic          irq_mask,
    output logic          take,
    output logic          sdo,
    output logic          irq,
    output logic          uflow
);
    typedef struct packed {
        sh_state_e     st;
        logic [DW-1:0] word;
        logic [LW-1:0] cnt;
        logic          sdo;
        logic          irq;
        logic          uflow;
    } shift_t;

    shift_t s_d, s_q;
    logic [DW-1:0] start_word;
    logic [LW-1:0] next_idx;

    assign take       = rdy && hvalid && (s_q.st == SH_EMPTY);
    assign start_word = take ? hdata : s_q.word;
    assign next_idx   = s_q.cnt - LW'(1);

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (take) begin
            s_d.word = hdata;
            s_d.st   = SH_LOADED;
            s_d.irq  = !dma_en && !irq_mask;
        end
        if (rdy && tick) begin
            if (s_q.st == SH_SHIFT) begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SH_EMPTY;
                    s_d.sdo = 1'b0;
                end else begin
                    s_d.cnt = next_idx;
                    s_d.sdo = s_q.word[next_idx];
                end
            end else if (fsync) begin
                if (s_q.st == SH_LOADED || take) begin
                    s_d.word = start_word;
                    s_d.st   = SH_SHIFT;
                    s_d.cnt  = len_m1;
                    s_d.sdo  = start_word[len_m1];
                end else begin
                    s_d.uflow = 1'b1;
                end
            end
        end
        if (clr) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo   = s_q.sdo;
    assign irq   = s_q.irq;
    assign uflow = s_q.uflow;
endmodule

// File: rtl/tx_serial_buf.sv
module tx_serial_buf #(
    parameter int DW         = 32,
    parameter int MIN_LEN    = 3,
    parameter int RDY_STAGES = 2,
    localparam int LW        = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] wlen_m1,
    input  logic          dma_en,
    input  logic          irq_mask,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          sclk_tick,
    input  logic          fsync,
    output logic          sdo,
    output logic          tx_irq,
    output logic          uflow
);
    localparam logic [LW-1:0] MIN_M1 = LW'(MIN_LEN - 1);

    logic          rdy;
    logic          clr;
    logic [LW-1:0] len_m1;
    logic          h_valid;
    logic [DW-1:0] h_data;
    logic          take;

    assign clr    = !en;
    assign len_m1 = (wlen_m1 < MIN_M1) ? MIN_M1 : wlen_m1;

    txb_enable_gate #(.STAGES(RDY_STAGES)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .ready (rdy)
    );

    txb_hold #(.DW(DW), .LW(LW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .rdy    (rdy),
        .wr     (wr),
        .wdata  (wdata),
        .len_m1 (len_m1),
        .take   (take),
        .valid  (h_valid),
        .data   (h_data)
    );

    txb_shifter #(.DW(DW), .LW(LW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .rdy      (rdy),
        .tick     (sclk_tick),
        .fsync    (fsync),
        .hvalid   (h_valid),
        .hdata    (h_data),
        .len_m1   (len_m1),
        .dma_en   (dma_en),
        .irq_mask (irq_mask),
        .take     (take),
        .sdo      (sdo),
        .irq      (tx_irq),
        .uflow    (uflow)
    );
endmodule

module tx_serial_buf_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic dma_en,
    input logic irq_mask,
    input logic sclk_tick,
    input logic fsync,
    input logic sdo,
    input logic tx_irq,
    input logic uflow
);
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (!$past(dma_en) && !$past(irq_mask)));

    p_uflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && en) |=> uflow);

    p_uflow_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uflow) |-> ($past(fsync) && $past(sclk_tick)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!uflow && !sdo && !tx_irq));

    p_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> (!tx_irq && !uflow));
endmodule

bind tx_serial_buf tx_serial_buf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .dma_en    (dma_en),
    .irq_mask  (irq_mask),
    .sclk_tick (sclk_tick),
    .fsync     (fsync),
    .sdo       (sdo),
    .tx_irq    (tx_irq),
    .uflow     (uflow)
);

// File: tb/tx_serial_buf_tb_top.sv
`timescale 1ns/1ps
module tx_serial_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [4:0]  wlen_m1 = 5'd31;
    logic        dma_en = 1'b0;
    logic        irq_mask = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        sclk_tick = 1'b0;
    logic        fsync = 1'b0;
    logic        sdo, tx_irq, uflow;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";
    int tdiv = 1;
    int tph = 0;

    always #2.5 clk = ~clk;

    tx_serial_buf dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .wlen_m1(wlen_m1),
        .dma_en(dma_en), .irq_mask(irq_mask), .wr(wr), .wdata(wdata),
        .sclk_tick(sclk_tick), .fsync(fsync),
        .sdo(sdo), .tx_irq(tx_irq), .uflow(uflow)
    );

    // behavioural reference
    logic [31:0] pend[$];
    bit m_rd1, m_rd2, m_in_sh, m_shifting, m_sdo, m_irq, m_uflow;
    int m_pos;

    always @(posedge clk) begin
        if (!rst_n || !en) begin
            pend.delete();
            m_rd1 = 0; m_rd2 = 0; m_in_sh = 0; m_shifting = 0;
            m_sdo = 0; m_irq = 0; m_uflow = 0; m_pos = 0;
        end else begin
            bit rdy, take, irq_new;
            int held, L;
            logic [31:0] msk;
            rdy = m_rd2;
            m_rd2 = m_rd1;
            m_rd1 = 1;
            irq_new = 0;
            if (rdy) begin
                L = (wlen_m1 < 5'd2) ? 3 : int'(wlen_m1) + 1;
                msk = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
                held = pend.size() - (m_in_sh ? 1 : 0);
                take = (held > 0) && !m_in_sh;
                if (take) begin
                    m_in_sh = 1;
                    irq_new = !dma_en && !irq_mask;
                end
                if (sclk_tick) begin
                    if (m_shifting) begin
                        if (m_pos == 0) begin
                            void'(pend.pop_front());
                            m_in_sh = 0; m_shifting = 0; m_sdo = 0;
                        end else begin
                            m_pos = m_pos - 1;
                            m_sdo = pend[0][m_pos];
                        end
                    end else if (fsync) begin
                        if (m_in_sh) begin
                            m_shifting = 1;
                            m_pos = L - 1;
                            m_sdo = pend[0][m_pos];
                        end else begin
                            m_uflow = 1;
                        end
                    end
                end
                if (wr && held == 0) pend.push_back(wdata & msk);
            end
            m_irq = irq_new;
        end
    end

    task automatic chk(string req, string what, logic got, logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tag, "sdo", sdo, m_sdo);
            chk(tag, "tx_irq", tx_irq, m_irq);
            chk(tag, "uflow", uflow, m_uflow);
        end
    end

    task automatic drive_tick();
        sclk_tick = (tph == 0);
        tph = (tph + 1) % tdiv;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr = 0; fsync = 0;
            drive_tick();
        end
    endtask

    task automatic put(logic [31:0] d);
        @(negedge clk);
        fsync = 0;
        drive_tick();
        wr = 1; wdata = d;
    endtask

    task automatic sync(bit with_wr, logic [31:0] d);
        do begin
            @(negedge clk);
            wr = 0; fsync = 0;
            drive_tick();
        end while (!sclk_tick);
        fsync = 1;
        wr = with_wr; wdata = d;
    endtask

    task automatic restart();
        @(negedge clk); wr = 0; fsync = 0; en = 0; drive_tick();
        @(negedge clk); en = 1; drive_tick();
        idle(3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset and disabled state
        chk("R1", "sdo in reset", sdo, 1'b0);
        chk("R1", "irq in reset", tx_irq, 1'b0);
        rst_n = 1;
        idle(3);
        chk("R1", "uflow idle", uflow, 1'b0);

        // R2: first two edges after enable ignore writes and syncs
        tag = "R2";
        @(negedge clk); en = 1; wr = 1; wdata = 32'hFFFF_FFFF; drive_tick();
        @(negedge clk); wr = 1; drive_tick();
        idle(2);
        sync(0, 0);
        idle(4);
        chk("R2", "uflow after ignored writes", uflow, 1'b1);

        // R9: disable clears the sticky flag
        tag = "R9";
        restart();
        chk("R9", "uflow cleared", uflow, 1'b0);

        // R3 R6: full word, slow tick
        tag = "R3";
        tdiv = 3; tph = 0;
        put(32'hA5C3_0F1E);
        idle(4);
        sync(0, 0);
        idle(110);

        // R5: two stored, third dropped; R8 on last frame
        tag = "R5";
        wlen_m1 = 5'd7;
        put(32'h0000_0081);
        idle(1);
        put(32'h0000_0042);
        put(32'h0000_00FF);
        idle(2);
        sync(0, 0); idle(30);
        sync(0, 0); idle(30);
        tag = "R8";
        sync(0, 0); idle(6);
        chk("R8", "uflow after dropped third", uflow, 1'b1);
        idle(5);
        chk("R8", "uflow still set", uflow, 1'b1);
        restart();

        // R4: upper bits discarded
        tag = "R4";
        put(32'hFFFF_FF5A);
        idle(3); sync(0, 0); idle(30);

        // R11: length clamp
        tag = "R11";
        wlen_m1 = 5'd0;
        put(32'hFFFF_FFFD);
        idle(3); sync(0, 0); idle(15);

        // R7: interrupt suppression
        tag = "R7";
        wlen_m1 = 5'd4;
        dma_en = 1;
        put(32'h0000_0015); idle(3); sync(0, 0); idle(25);
        dma_en = 0; irq_mask = 1;
        put(32'h0000_000A); idle(3); sync(0, 0); idle(25);
        irq_mask = 0;

        // R10: sync during shifting ignored
        tag = "R10";
        tdiv = 2; tph = 0;
        wlen_m1 = 5'd9;
        put(32'h0000_02B7); idle(3);
        sync(0, 0);
        idle(4);
        sync(0, 0);
        idle(30);
        chk("R10", "no uflow from mid-word sync", uflow, 1'b0);

        // R12: sync coincides with handover
        tag = "R12";
        tdiv = 1; tph = 0;
        wlen_m1 = 5'd15;
        put(32'h0000_C35A);
        @(negedge clk); wr = 0; drive_tick(); fsync = 1;
        @(negedge clk); fsync = 0; drive_tick();
        chk("R12", "irq on handover", tx_irq, 1'b1);
        chk("R12", "msb started", sdo, 1'b1);
        chk("R12", "no uflow", uflow, 1'b0);
        idle(25);

        // R8: write and sync together on empty buffer
        tag = "R8";
        sync(1, 32'h0000_8001);
        idle(3);
        chk("R8", "uflow with simultaneous write", uflow, 1'b1);
        sync(0, 0); idle(25);

        // R9: disable mid-word
        tag = "R9";
        put(32'h0000_FFFF); idle(3); sync(0, 0); idle(4);
        @(negedge clk); en = 0; wr = 0; fsync = 0; drive_tick();
        @(negedge clk); drive_tick();
        chk("R9", "sdo low after disable", sdo, 1'b0);
        chk("R9", "uflow low after disable", uflow, 1'b0);
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule